// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A single holding register sits in front of a frame shift register. Software writes a character into the holding register. On the next bit tick in which the shifter is free, the character moves into the shifter and is sent as a start bit, the data bits, an optional parity bit and one or two stop bits. Character length can be 5 to 9 bits. The ninth bit comes from a separate input that is captured together with the write.

The bit rate comes from a programmable prescaler followed by an oversampling counter. The counter divides by 16, or by 8 when the double-speed input is set. Two flags report progress. The buffer-empty flag follows the holding register. The transmit-done flag rises only when the line has gone idle with nothing queued. Each flag drives its own interrupt request through a separate enable. When the transmitter enable is dropped, new writes are refused, but a frame in flight and a queued character are still sent to the end.

Top module: `sertx_top`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits.
- R2: `char_size_i` selects the data length: 0→5, 1→6, 2→7, 3→8 and 7→9 bits, with 4 to 6 treated as 8. Bit 8 of a 9-bit character is the value of `bit9_i` at the write.
- R3: `parity_i` selects the parity bit: 0 or 1 gives none, 2 gives even (total count of ones is even), 3 gives odd.
- R4: `two_stop_i` = 0 sends one high stop bit and `two_stop_i` = 1 sends two.
- R5: One bit lasts (`div_i`+1)×16 clock cycles, or (`div_i`+1)×8 when `dbl_speed_i` = 1.
- R6: `empty_o` is 1 after reset. It drops in the cycle after an accepted write. It rises in the same cycle in which the held character enters the shifter, which is also the cycle in which the start bit appears. A write while `empty_o` = 0 is ignored.
- R7: A character that is queued when the last stop bit ends starts at once, with no idle gap between frames.
- R8: `done_o` is 0 after reset. It is set when the last stop bit ends and no character is queued, so it stays 0 between back-to-back frames.
- R9: `done_o` is cleared by a one-cycle pulse on `done_ack_i` (interrupt acknowledge) or on `done_clr_i` (write-one clear).
- R10: `empty_irq_o` = `empty_o` AND `empty_ie_i`, and `done_irq_o` = `done_o` AND `done_ie_i`.
- R11: A write while `tx_en_i` = 0 is ignored. Clearing `tx_en_i` still lets the frame in flight and a queued character be sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable |
| dbl_speed_i | input | 1 | Selects 8 oversample ticks per bit instead of 16 |
| div_i | input | DIV_W | Prescaler reload value; the prescaler divides by `div_i`+1 |
| char_size_i | input | 3 | Character length code |
| parity_i | input | 2 | Parity mode code |
| two_stop_i | input | 1 | Selects two stop bits |
| bit9_i | input | 1 | Ninth data bit, captured with the write |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Data bits 7:0 |
| empty_ie_i | input | 1 | Buffer-empty interrupt enable |
| done_ie_i | input | 1 | Transmit-done interrupt enable |
| done_ack_i | input | 1 | Interrupt acknowledge for the done flag |
| done_clr_i | input | 1 | Write-one clear for the done flag |
| txd_o | output | 1 | Serial output |
| empty_o | output | 1 | Holding register can accept a write |
| done_o | output | 1 | Transmit-done flag |
| empty_irq_o | output | 1 | Buffer-empty interrupt request |
| done_irq_o | output | 1 | Transmit-done interrupt request |

## Verification
A bad bit counter or shift register shows up within one frame as a wrong captured data, parity or stop bit, or as a start bit that lasts the wrong number of cycles. A holding register that gets out of step with the shifter shows up at `empty_o` in the cycle of the load: it either fails to rise together with the start bit, or it lets a third character through. A flag-set error shows on `done_o` within half a bit of the last stop bit, or as a rise between two back-to-back frames, where the flag then stays high until it is cleared.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_MAX = 9;
  localparam int FRAME_W  = 1 + DATA_MAX + 1 + 2;
  localparam int LEN_W    = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    PAR_OFF  = 2'd0,
    PAR_RSV  = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_ODD  = 2'd3
  } par_e;

  typedef struct packed {
    logic [2:0] size;
    par_e       par;
    logic       two_stop;
  } fmt_t;

  typedef struct packed {
    logic [FRAME_W-1:0] bits;
    logic [LEN_W-1:0]   len;
  } frame_t;

  function automatic logic [3:0] char_len(logic [2:0] s);
    case (s)
      3'd0:    char_len = 4'd5;
      3'd1:    char_len = 4'd6;
      3'd2:    char_len = 4'd7;
      3'd7:    char_len = 4'd9;
      default: char_len = 4'd8;
    endcase
  endfunction

  // start at bit 0, unused positions stay high (stop / idle)
  function automatic frame_t build_frame(logic [DATA_MAX-1:0] d, fmt_t f);
    frame_t fr;
    logic [3:0] n;
    logic p;
    int pos;
    n       = char_len(f.size);
    fr.bits = '1;
    fr.bits[0] = 1'b0;
    p = (f.par == PAR_ODD);
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(n)) begin
        fr.bits[1+i] = d[i];
        p = p ^ d[i];
      end
    end
    pos = 1 + int'(n);
    if (f.par[1]) begin
      fr.bits[pos] = p;
      pos = pos + 1;
    end
    pos = pos + (f.two_stop ? 2 : 1);
    fr.len = LEN_W'(pos);
    return fr;
  endfunction
endpackage

// File: rtl/sertx_ticker.sv
module sertx_ticker #(
  parameter int DIV_W = 12,
  parameter int OS_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             dbl_i,
  output logic             bit_tick_o
);
  localparam logic [OS_W-1:0] OS_LAST_N = OS_W'(15);
  localparam logic [OS_W-1:0] OS_LAST_D = OS_W'(7);

  logic [DIV_W-1:0] pre_q;
  logic [OS_W-1:0]  os_q;
  logic             os_tick;
  logic [OS_W-1:0]  os_last;
  logic             os_wrap;

  assign os_tick    = (pre_q == '0);
  assign os_last    = dbl_i ? OS_LAST_D : OS_LAST_N;
  assign os_wrap    = (os_q >= os_last);
  assign bit_tick_o = os_tick & os_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      os_q  <= '0;
    end else begin
      pre_q <= os_tick ? div_i : pre_q - 1'b1;
      if (os_tick) os_q <= os_wrap ? '0 : os_q + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_status.sv
module sertx_status
  import sertx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_en_i,
  input  logic                wr_i,
  input  logic [DATA_MAX-1:0] wr_data_i,
  input  logic                load_i,
  input  logic                frame_end_i,
  input  logic                done_ack_i,
  input  logic                done_clr_i,
  input  logic                empty_ie_i,
  input  logic                done_ie_i,
  output logic                buf_full_o,
  output logic [DATA_MAX-1:0] buf_data_o,
  output logic                empty_o,
  output logic                done_o,
  output logic                empty_irq_o,
  output logic                done_irq_o
);
  logic full_q, done_q, accept;
  logic [DATA_MAX-1:0] data_q;

  assign accept = wr_i & tx_en_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (accept) begin
        full_q <= 1'b1;
        data_q <= wr_data_i;
      end else if (load_i) begin
        full_q <= 1'b0;
      end
      if (frame_end_i)                  done_q <= 1'b1;
      else if (done_ack_i | done_clr_i) done_q <= 1'b0;
    end
  end

  assign buf_full_o  = full_q;
  assign buf_data_o  = data_q;
  assign empty_o     = ~full_q;
  assign done_o      = done_q;
  assign empty_irq_o = ~full_q & empty_ie_i;
  assign done_irq_o  = done_q & done_ie_i;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                buf_full_i,
  input  logic [DATA_MAX-1:0] buf_data_i,
  input  fmt_t                fmt_i,
  output logic                load_o,
  output logic                frame_end_o,
  output logic                txd_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;
  logic               busy_q, last;
  frame_t             nxt;

  always_comb nxt = build_frame(buf_data_i, fmt_i);

  assign last        = (cnt_q == LEN_W'(1));
  assign load_o      = bit_tick_i & buf_full_i & (~busy_q | last);
  assign frame_end_o = bit_tick_i & busy_q & last & ~buf_full_i;
  assign txd_o       = ~busy_q | sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_o) begin
      sh_q   <= nxt.bits;
      cnt_q  <= nxt.len;
      busy_q <= 1'b1;
    end else if (bit_tick_i && busy_q) begin
      sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
      cnt_q <= cnt_q - 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic             dbl_speed_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [2:0]       char_size_i,
  input  logic [1:0]       parity_i,
  input  logic             two_stop_i,
  input  logic             bit9_i,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic             empty_ie_i,
  input  logic             done_ie_i,
  input  logic             done_ack_i,
  input  logic             done_clr_i,
  output logic             txd_o,
  output logic             empty_o,
  output logic             done_o,
  output logic             empty_irq_o,
  output logic             done_irq_o
);
  logic                bit_tick, load, frame_end, buf_full;
  logic [DATA_MAX-1:0] buf_data;
  fmt_t                fmt;

  assign fmt.size     = char_size_i;
  assign fmt.par      = par_e'(parity_i);
  assign fmt.two_stop = two_stop_i;

  sertx_ticker #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .div_i, .dbl_i(dbl_speed_i), .bit_tick_o(bit_tick)
  );

  sertx_status u_stat (
    .clk_i, .rst_ni, .tx_en_i, .wr_i,
    .wr_data_i  ({bit9_i, wr_data_i}),
    .load_i     (load),
    .frame_end_i(frame_end),
    .done_ack_i, .done_clr_i, .empty_ie_i, .done_ie_i,
    .buf_full_o (buf_full),
    .buf_data_o (buf_data),
    .empty_o, .done_o, .empty_irq_o, .done_irq_o
  );

  sertx_shifter u_shift (
    .clk_i, .rst_ni,
    .bit_tick_i (bit_tick),
    .buf_full_i (buf_full),
    .buf_data_i (buf_data),
    .fmt_i      (fmt),
    .load_o     (load),
    .frame_end_o(frame_end),
    .txd_o
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic empty_o,
  input logic done_o,
  input logic done_ack_i,
  input logic done_clr_i,
  input logic done_ie_i,
  input logic done_irq_o,
  input logic txd_o
);
  assert_write_fills_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && tx_en_i && empty_o) |=> !empty_o);

  assert_load_starts_frame_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(empty_o) |-> !txd_o);

  assert_done_line_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> txd_o);

  assert_done_nothing_queued_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(empty_o));

  assert_done_clear_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(done_ack_i || done_clr_i));

  assert_done_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> (done_o && done_ie_i));

  assert_disabled_write_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tx_en_i && empty_o) |=> empty_o);
endmodule

bind sertx_top sertx_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .wr_i       (wr_i),
  .empty_o    (empty_o),
  .done_o     (done_o),
  .done_ack_i (done_ack_i),
  .done_clr_i (done_clr_i),
  .done_ie_i  (done_ie_i),
  .done_irq_o (done_irq_o),
  .txd_o      (txd_o)
);

// File: tb/sertx_top_test.sv
module sertx_top_test;
  localparam int DIV_W = 12;
  localparam int WD_CYCLES = 200000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en, dbl, two_stop, bit9, wr, e_ie, d_ie, d_ack, d_clr;
  logic [DIV_W-1:0] div;
  logic [2:0] csize;
  logic [1:0] par;
  logic [7:0] wdata;
  logic txd, empty, done, e_irq, d_irq;

  int n_chk = 0, n_fail = 0;
  int P = 16;
  bit finished = 0;

  always #4 clk = ~clk;

  sertx_top #(.DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .dbl_speed_i(dbl), .div_i(div),
    .char_size_i(csize), .parity_i(par), .two_stop_i(two_stop), .bit9_i(bit9),
    .wr_i(wr), .wr_data_i(wdata), .empty_ie_i(e_ie), .done_ie_i(d_ie),
    .done_ack_i(d_ack), .done_clr_i(d_clr), .txd_o(txd), .empty_o(empty),
    .done_o(done), .empty_irq_o(e_irq), .done_irq_o(d_irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_char(input logic [8:0] d);
    @(negedge clk);
    wr = 1'b1; wdata = d[7:0]; bit9 = d[8];
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); d_ack = 1'b1; @(negedge clk); d_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); d_clr = 1'b1; @(negedge clk); d_clr = 1'b0;
  endtask

  task automatic cap(input int nb, input bit has_par, input int nstop,
                     output logic [8:0] d, output logic pb, output bit stops_ok, output int waited);
    waited = 0; d = '0; pb = 1'b0; stops_ok = 1;
    while (txd !== 1'b0 && waited < 20 * P) begin @(negedge clk); waited++; end
    cyc(P / 2);
    for (int i = 0; i < nb; i++) begin cyc(P); d[i] = txd; end
    if (has_par) begin cyc(P); pb = txd; end
    for (int s = 0; s < nstop; s++) begin cyc(P); if (txd !== 1'b1) stops_ok = 0; end
  endtask

  function automatic logic par_of(input logic [8:0] d, input int nb, input bit odd);
    logic p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 20 * P) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    chk(empty === 1'b1, "R6", "empty after reset", int'(empty), 1);
    chk(done === 1'b0, "R8", "done after reset", int'(done), 0);
    chk(txd === 1'b1, "R1", "idle line", int'(txd), 1);
    chk(e_irq === 1'b0 && d_irq === 1'b0, "R10", "irqs masked", int'({e_irq, d_irq}), 0);
  endtask

  task automatic t_basic_8n1();
    logic [8:0] d; logic pb; bit so; int w;
    csize = 3'd3; par = 2'd0; two_stop = 1'b0;
    wr_char(9'h0A5);
    cap(8, 0, 1, d, pb, so, w);
    chk(d[7:0] === 8'hA5, "R1", "8N1 data lsb first", int'(d), 'hA5);
    chk(so, "R4", "single stop high", int'(so), 1);
    chk(done === 1'b0, "R8", "done before stop end", int'(done), 0);
    cyc(P / 2 + 2);
    chk(done === 1'b1 && txd === 1'b1, "R8", "done after stop", int'({done, txd}), 3);
    pulse_clr();
    chk(done === 1'b0, "R9", "write-one clear", int'(done), 0);
  endtask

  task automatic t_sizes();
    logic [8:0] d; logic pb; bit so; int w;
    par = 2'd0; two_stop = 1'b0;
    for (int s = 0; s < 3; s++) begin
      csize = 3'(s);
      wr_char(9'h0B6);
      cap(5 + s, 0, 1, d, pb, so, w);
      chk(d == (9'h0B6 & ((9'h1 << (5 + s)) - 9'h1)) && so, "R2", "short char size",
          int'(d), int'(9'h0B6 & ((9'h1 << (5 + s)) - 9'h1)));
      wait_done(); pulse_ack();
    end
  endtask

  task automatic t_nine();
    logic [8:0] d; logic pb; bit so; int w;
    csize = 3'd7; par = 2'd2; two_stop = 1'b1;
    wr_char(9'h13C);
    cap(9, 1, 2, d, pb, so, w);
    chk(d === 9'h13C, "R2", "ninth bit from bit9", int'(d), 'h13C);
    chk(pb === par_of(9'h13C, 9, 0), "R3", "even parity on 9 bits", int'(pb), int'(par_of(9'h13C, 9, 0)));
    chk(so, "R4", "two stop bits high", int'(so), 1);
    wait_done(); pulse_ack();
    two_stop = 1'b0;
  endtask

  task automatic t_parity();
    logic [8:0] d; logic pb; bit so; int w;
    csize = 3'd3;
    par = 2'd3;
    wr_char(9'h007);
    cap(8, 1, 1, d, pb, so, w);
    chk(pb === 1'b0 && d[7:0] === 8'h07, "R3", "odd parity", int'(pb), 0);
    wait_done(); pulse_ack();
    par = 2'd2;
    wr_char(9'h007);
    cap(8, 1, 1, d, pb, so, w);
    chk(pb === 1'b1 && so, "R3", "even parity", int'(pb), 1);
    wait_done(); pulse_ack();
    par = 2'd0;
  endtask

  task automatic t_period(input bit db, input int dv);
    int run = 0, n = 0, exp;
    dbl = db; div = DIV_W'(dv);
    exp = (dv + 1) * (db ? 8 : 16);
    csize = 3'd3; par = 2'd0;
    cyc(40);
    wr_char(9'h001);
    while (txd !== 1'b0 && n < 40 * exp) begin @(negedge clk); n++; end
    while (txd === 1'b0 && run < 4 * exp) begin @(negedge clk); run++; end
    chk(run == exp, "R5", "start bit length", run, exp);
    P = exp;
    wait_done(); pulse_ack();
    dbl = 1'b0; div = '0; P = 16;
    cyc(40);
  endtask

  task automatic t_buffer();
    logic [8:0] d; logic pb; bit so; int w, n = 0;
    csize = 3'd3; par = 2'd0; two_stop = 1'b0;
    wr_char(9'h03C);
    chk(empty === 1'b0, "R6", "empty drops on write", int'(empty), 0);
    while (empty !== 1'b1 && n < 4 * P) begin @(negedge clk); n++; end
    chk(txd === 1'b0, "R6", "empty rises with start bit", int'(txd), 0);
    wr_char(9'h0C3);
    chk(empty === 1'b0, "R6", "buffer held", int'(empty), 0);
    wr_char(9'h0FF);
    cap(8, 0, 1, d, pb, so, w);
    chk(d[7:0] === 8'h3C, "R6", "first char", int'(d), 'h3C);
    cap(8, 0, 1, d, pb, so, w);
    chk(w <= P / 2 + 2, "R7", "no gap between frames", w, P / 2);
    chk(d[7:0] === 8'hC3, "R6", "second char, third ignored", int'(d), 'hC3);
    chk(done === 1'b0, "R8", "no done between frames", int'(done), 0);
    cyc(P / 2 + 2);
    chk(done === 1'b1, "R8", "done after last frame", int'(done), 1);
    n = 0;
    for (int i = 0; i < 3 * P; i++) begin @(negedge clk); if (txd !== 1'b1) n++; end
    chk(n == 0, "R6", "full-buffer write not sent", n, 0);
    pulse_ack();
    chk(done === 1'b0, "R9", "ack clears done", int'(done), 0);
  endtask

  task automatic t_irq();
    logic [8:0] d; logic pb; bit so; int w;
    e_ie = 1'b1; cyc(1);
    chk(e_irq === 1'b1, "R10", "empty irq enabled", int'(e_irq), 1);
    e_ie = 1'b0; cyc(1);
    chk(e_irq === 1'b0, "R10", "empty irq masked", int'(e_irq), 0);
    wr_char(9'h055);
    cap(8, 0, 1, d, pb, so, w);
    wait_done();
    chk(d_irq === 1'b0, "R10", "done irq masked", int'(d_irq), 0);
    d_ie = 1'b1; cyc(1);
    chk(d_irq === 1'b1, "R10", "done irq enabled", int'(d_irq), 1);
    pulse_ack();
    chk(d_irq === 1'b0, "R10", "done irq cleared", int'(d_irq), 0);
    d_ie = 1'b0;
  endtask

  task automatic t_enable();
    logic [8:0] d; logic pb; bit so; int w, n = 0;
    tx_en = 1'b0;
    wr_char(9'h011);
    chk(empty === 1'b1, "R11", "disabled write ignored", int'(empty), 1);
    for (int i = 0; i < 3 * P; i++) begin @(negedge clk); if (txd !== 1'b1) n++; end
    chk(n == 0, "R11", "line idle while disabled", n, 0);
    tx_en = 1'b1;
    wr_char(9'h066);
    n = 0;
    while (empty !== 1'b1 && n < 4 * P) begin @(negedge clk); n++; end
    wr_char(9'h099);
    tx_en = 1'b0;
    cap(8, 0, 1, d, pb, so, w);
    chk(d[7:0] === 8'h66, "R11", "frame in flight completes", int'(d), 'h66);
    cap(8, 0, 1, d, pb, so, w);
    chk(d[7:0] === 8'h99 && so, "R11", "queued char drains", int'(d), 'h99);
    wait_done();
    chk(done === 1'b1, "R11", "done after drain", int'(done), 1);
    pulse_ack();
    tx_en = 1'b1;
  endtask

  initial begin
    tx_en = 1'b1; dbl = 1'b0; div = '0; csize = 3'd3; par = 2'd0; two_stop = 1'b0;
    bit9 = 1'b0; wr = 1'b0; wdata = '0; e_ie = 1'b0; d_ie = 1'b0; d_ack = 1'b0; d_clr = 1'b0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_basic_8n1();
    t_sizes();
    t_nine();
    t_parity();
    t_period(1'b0, 0);
    t_period(1'b1, 0);
    t_period(1'b1, 1);
    t_period(1'b0, 2);
    t_buffer();
    t_irq();
    t_enable();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule